// File: doc/BRIEF.md
# Shared Configuration Shift-Register Port

This block holds two serial configuration registers of one chip: a probe register, which selects internal test points, and a slow-control register, which carries the static settings of the chip. Both registers are loaded and read back through one shared set of pins: serial data in, serial data out, shift clock and reset. A select input decides which register these pins act on. The register that is not selected ignores shift and reset activity and keeps its contents. Select low means probe, so a pin left at its default cannot disturb the slow-control settings.

A reset applied while the slow-control register is selected loads a preset pattern. Each bit has its own preset value, set by a parameter. A reset applied while the probe register is selected clears the probe register. The serial output comes from one extra flip-flop that captures the last bit of the selected register on the falling clock edge. Several chips can therefore be wired in a chain, with each chip's output feeding the next chip's input on the same shift clock. The next chip samples a value that has been stable for half a period.

Top module: `cfg_shared_port`

## Requirements
- R1: With `rst` low and `sel` = 0, each rising edge of `clk` shifts the probe register by one place toward its most significant bit, with `sdi` entering bit 0. The first bit shifted in ends up in the MSB.
- R2: With `rst` low and `sel` = 1, each rising edge of `clk` shifts the slow-control register in the same way, with `sdi` entering bit 0.
- R3: The register that is not selected keeps its contents across any number of rising edges, and across edges where `rst` is high.
- R4: A rising edge with `rst` high and `sel` = 1 loads bit i of the slow-control register from bit i of `SC_DEFAULT`, and `sdi` is ignored. The bench uses the 4-bit preset 4'b1011, so the field in bits 2..0 reads 0,1,1 from bit 2 down to bit 0.
- R5: A rising edge with `rst` high and `sel` = 0 clears every probe bit to 0, and `sdi` is ignored.
- R6: `sdo` changes only on the falling edge of `clk`. At that edge it takes the MSB of the register that `sel` selects at that moment. It keeps that value through the following rising edge.
- R7: A bit presented on `sdi` at rising edge k, with a register of length N selected, appears on `sdo` after the falling edge that follows rising edge k+N-1.
- R8: Consider chips chained `sdo` to `sdi` on a common clock, with the same register selected in each and selected lengths summing to L. A bit entering the first chip at rising edge k appears on the last chip's `sdo` after the falling edge that follows rising edge k+L-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared shift clock |
| rst | input | 1 | Shared synchronous active-high reset; acts on the selected register only |
| sel | input | 1 | Register select: 0 = probe, 1 = slow control |
| sdi | input | 1 | Shared serial data input |
| sdo | output | 1 | Serial data output, retimed on the falling edge |

## Verification
Register updates happen at a rising edge, but they become visible only at the following falling edge, when the retiming flop captures the selected MSB. The bench therefore sets its inputs a few nanoseconds after a falling edge. It samples `sdo` a few nanoseconds after the next falling edge, and again just after the rising edge in between to confirm that the output held. A bit of a single chip is checked N ticks after it entered. A bit of the two-chip chain is checked L ticks after it entered, which includes the half-cycle hand-off between the chips. The unselected register is checked by selecting it later and shifting its contents out through `sdo`.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic {
        SEL_PROBE = 1'b0,
        SEL_SLOW  = 1'b1
    } reg_sel_e;

    // Per-register control derived from the shared pins
    typedef struct packed {
        logic load;   // preset/clear on this edge
        logic shift;  // shift on this edge
    } lane_ctl_t;

    typedef struct packed {
        lane_ctl_t probe;
        lane_ctl_t slow;
    } port_ctl_t;

    function automatic lane_ctl_t lane_ctl(input logic mine, input logic rst_in);
        lane_ctl_t c;
        c.load  = mine & rst_in;
        c.shift = mine & ~rst_in;
        return c;
    endfunction

endpackage

// File: rtl/cfg_sel_decode.sv
module cfg_sel_decode
    import cfg_port_pkg::*;
(
    input  logic      sel,
    input  logic      rst,
    output port_ctl_t ctl
);
    reg_sel_e which;

    always_comb begin
        which     = reg_sel_e'(sel);
        ctl.probe = lane_ctl(which == SEL_PROBE, rst);
        ctl.slow  = lane_ctl(which == SEL_SLOW, rst);
    end
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
    parameter int               WIDTH  = 8,
    parameter logic [WIDTH-1:0] PRESET = '0
) (
    input  logic             clk,
    input  logic             load,
    input  logic             shift,
    input  logic             ser_in,
    output logic [WIDTH-1:0] bits_q
);
    // One flop per bit, each with its own preset value
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic nxt;
        if (gi == 0) begin : g_head
            assign nxt = ser_in;
        end else begin : g_body
            assign nxt = bits_q[gi-1];
        end

        always_ff @(posedge clk) begin
            if (load) begin
                bits_q[gi] <= PRESET[gi];
            end else if (shift) begin
                bits_q[gi] <= nxt;
            end
        end
    end
endmodule

// File: rtl/cfg_chain_retime.sv
module cfg_chain_retime
    import cfg_port_pkg::*;
(
    input  logic clk,
    input  logic sel,
    input  logic probe_tail,
    input  logic slow_tail,
    output logic sdo
);
    logic tail_mux;

    always_comb begin
        tail_mux = (reg_sel_e'(sel) == SEL_SLOW) ? slow_tail : probe_tail;
    end

    // Opposite-edge capture: the next chip samples on the rising edge
    always_ff @(negedge clk) begin
        sdo <= tail_mux;
    end
endmodule

// File: rtl/cfg_shared_port.sv
module cfg_shared_port
    import cfg_port_pkg::*;
#(
    parameter int                 PR_LEN     = 16,
    parameter int                 SC_LEN     = 12,
    parameter logic [SC_LEN-1:0]  SC_DEFAULT = 12'b1010_0110_0011
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sdi,
    output logic sdo
);
    localparam int PR_MSB = PR_LEN - 1;
    localparam int SC_MSB = SC_LEN - 1;

    port_ctl_t          ctl;
    logic [PR_LEN-1:0]  pr_q;
    logic [SC_LEN-1:0]  sc_q;

    cfg_sel_decode u_dec (
        .sel (sel),
        .rst (rst),
        .ctl (ctl)
    );

    cfg_shift_reg #(
        .WIDTH  (PR_LEN),
        .PRESET ('0)
    ) u_probe (
        .clk    (clk),
        .load   (ctl.probe.load),
        .shift  (ctl.probe.shift),
        .ser_in (sdi),
        .bits_q (pr_q)
    );

    cfg_shift_reg #(
        .WIDTH  (SC_LEN),
        .PRESET (SC_DEFAULT)
    ) u_slow (
        .clk    (clk),
        .load   (ctl.slow.load),
        .shift  (ctl.slow.shift),
        .ser_in (sdi),
        .bits_q (sc_q)
    );

    cfg_chain_retime u_tail (
        .clk        (clk),
        .sel        (sel),
        .probe_tail (pr_q[PR_MSB]),
        .slow_tail  (sc_q[SC_MSB]),
        .sdo        (sdo)
    );
endmodule

// File: rtl/cfg_shared_port_chk.sv
module cfg_shared_port_chk #(
    parameter int                PR_LEN     = 16,
    parameter int                SC_LEN     = 12,
    parameter logic [SC_LEN-1:0] SC_DEFAULT = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              sel,
    input logic              sdi,
    input logic              sdo,
    input logic [PR_LEN-1:0] pr_q,
    input logic [SC_LEN-1:0] sc_q
);
    logic pr_seen = 1'b0;
    logic sc_seen = 1'b0;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst && !sel) pr_seen <= 1'b1;
        if (rst && sel)  sc_seen <= 1'b1;
    end
    assign armed = pr_seen & sc_seen;

    AST_PROBE_SHIFT: assert property (@(posedge clk) disable iff (rst || !armed)
        !sel |=> pr_q == {$past(pr_q[PR_LEN-2:0]), $past(sdi)}); // R1

    AST_SLOW_SHIFT: assert property (@(posedge clk) disable iff (rst || !armed)
        sel |=> sc_q == {$past(sc_q[SC_LEN-2:0]), $past(sdi)}); // R2

    AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (!armed)
        sel |=> $stable(pr_q)); // R3

    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!armed)
        !sel |=> $stable(sc_q)); // R3

    AST_SLOW_PRESET: assert property (@(posedge clk) disable iff (!armed)
        (rst && sel) |=> sc_q == SC_DEFAULT); // R4

    AST_PROBE_CLEAR: assert property (@(posedge clk) disable iff (!armed)
        (rst && !sel) |=> pr_q == '0); // R5

    AST_SDO_RETIME: assert property (@(negedge clk) disable iff (rst)
        armed |=> sdo == $past(sel ? sc_q[SC_LEN-1] : pr_q[PR_LEN-1])); // R6
endmodule

bind cfg_shared_port cfg_shared_port_chk #(
    .PR_LEN     (PR_LEN),
    .SC_LEN     (SC_LEN),
    .SC_DEFAULT (SC_DEFAULT)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .sel  (sel),
    .sdi  (sdi),
    .sdo  (sdo),
    .pr_q (pr_q),
    .sc_q (sc_q)
);

// File: tb/cfg_shared_port_tb_top.sv
module cfg_shared_port_tb_top;
    localparam int        P1 = 5;
    localparam int        S1 = 4;
    localparam logic [3:0] D1 = 4'b1011;
    localparam int        P2 = 6;
    localparam int        S2 = 3;
    localparam logic [2:0] D2 = 3'b011;
    localparam int        LCH = P1 + P2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0;
    logic sdi = 1'b0;
    logic sdo1, sdo2;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit started  = 1'b0;

    // bench-side models
    logic [P1-1:0] m1p = '0;
    logic [S1-1:0] m1s = '0;
    logic [P2-1:0] m2p = '0;
    logic [S2-1:0] m2s = '0;
    logic e1 = 1'b0;
    logic e2 = 1'b0;
    logic hist [0:255];

    always #10 clk = ~clk;

    cfg_shared_port #(.PR_LEN(P1), .SC_LEN(S1), .SC_DEFAULT(D1)) dut_i (
        .clk(clk), .rst(rst), .sel(sel), .sdi(sdi), .sdo(sdo1));

    cfg_shared_port #(.PR_LEN(P2), .SC_LEN(S2), .SC_DEFAULT(D2)) chain_i (
        .clk(clk), .rst(rst), .sel(sel), .sdi(sdo1), .sdo(sdo2));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: inputs set mid-low phase, sdo checked after rising and falling edges
    task automatic tick(input logic r, input logic s, input logic d, input string req);
        logic in2;
        rst = r; sel = s; sdi = d;
        @(posedge clk);
        #2;
        if (started) begin
            check("R6", sdo1, e1);
            check("R6", sdo2, e2);
        end
        in2 = e1;
        if (s) begin
            m1s = r ? D1 : {m1s[S1-2:0], d};
            m2s = r ? D2 : {m2s[S2-2:0], in2};
        end else begin
            m1p = r ? '0 : {m1p[P1-2:0], d};
            m2p = r ? '0 : {m2p[P2-2:0], in2};
        end
        e1 = s ? m1s[S1-1] : m1p[P1-1];
        e2 = s ? m2s[S2-1] : m2p[P2-1];
        @(negedge clk);
        #2;
        check(req, sdo1, e1);
        check(req, sdo2, e2);
        started = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        #2;
        // reset both registers of both chips
        tick(1'b1, 1'b1, 1'b1, "R4");
        check("R4", sdo1, D1[S1-1]);
        check("R4", sdo2, D2[S2-1]);
        tick(1'b1, 1'b0, 1'b1, "R5");
        check("R5", sdo1, 1'b0);

        // shift the slow-control preset out: 1011 -> sdo 0,1,1 then sdi bits
        for (int i = 0; i < S1; i++) tick(1'b0, 1'b1, 1'b0, "R4");

        // R1 / R7: every probe pattern, latency checked from bit history
        for (int p = 0; p < (1 << P1); p++) begin
            for (int i = 0; i < P1; i++) begin
                int k = p * P1 + i;
                logic b = 1'((p >> (P1 - 1 - i)) & 1);
                hist[k % 256] = b;
                tick(1'b0, 1'b0, b, "R1");
                if (k >= P1 - 1) check("R7", sdo1, hist[(k - P1 + 1) % 256]);
            end
        end

        // R2: every slow-control pattern
        for (int p = 0; p < (1 << S1); p++)
            for (int i = 0; i < S1; i++)
                tick(1'b0, 1'b1, 1'((p >> (S1 - 1 - i)) & 1), "R2");

        // R3: load slow control 1001, work the probe and reset it, read slow control back
        for (int i = 0; i < S1; i++) tick(1'b0, 1'b1, 1'((4'b1001 >> (S1 - 1 - i)) & 1), "R2");
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b0, 1'(i % 3 == 0), "R1");
        tick(1'b1, 1'b0, 1'b1, "R5");
        check("R5", sdo1, 1'b0);
        for (int i = 0; i < S1; i++) tick(1'b0, 1'b1, 1'b0, "R3");
        // probe held while slow control shifted: read it back
        for (int i = 0; i < P1; i++) tick(1'b0, 1'b0, 1'b1, "R3");

        // R4 again mid-stream
        tick(1'b0, 1'b1, 1'b0, "R2");
        tick(1'b1, 1'b1, 1'b0, "R4");
        check("R4", sdo1, D1[S1-1]);
        for (int i = 0; i < S1; i++) tick(1'b0, 1'b1, 1'b1, "R4");

        // R8: two-chip chain through the probe registers
        for (int k = 0; k < 60; k++) begin
            logic b = 1'(((k * 7 + 3) >> 2) & 1);
            hist[k % 256] = b;
            tick(1'b0, 1'b0, b, "R8");
            if (k >= LCH - 1) check("R8", sdo2, hist[(k - LCH + 1) % 256]);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule